// File: doc/BRIEF.md
# Non-destructive memory size prober

This engine works out how much RAM is attached behind a word-wide memory port. It drives the port through a small synchronous master interface: request, write enable, byte address, write data, read data and an acknowledge. When it gets a start pulse, it first reads the word at the base of the window and keeps a copy. It then tests whether memory is present by writing two complementary patterns to the base word. Between each write and its readback it reads an unrelated address, so that a floating data bus cannot return the value just written.

If memory is present, the engine tests byte offsets 4, 8, 16 and so on. At each offset it reads the test word and writes its bitwise inverse to the base word. It then reads both locations. When they are equal, the address has wrapped back to the base, and the current offset is the size. The base word is the only location that is ever written, and it is restored before the result is reported. The method only gives a correct answer for memories whose size is a power of two. If the probe reaches the configured maximum without seeing a wrap, the result is marked undetermined.

Top module: `memsize_probe`

## Requirements
- R1: After a start pulse from idle, the first bus access is a read of the base address, before any write takes place.
- R2: Presence test, first pattern: the engine writes 0x5555AAAA to the base address, reads the dummy address, then reads the base address. If that readback differs, the run ends with size 0 and valid 1. A bus that holds its last driven value with no memory behind it is therefore reported as size 0.
- R3: Presence test, second pattern: the engine writes 0xAAAA5555 to the base address, reads the dummy address, then reads the base address. If that readback differs, the run ends with size 0 and valid 1. A data bit stuck at 0 is therefore reported as size 0.
- R4: For a power-of-two memory of S bytes, where 4 ≤ S < MAX_BYTES, the run reports size S with valid 1. The run takes 8 + 4·(log2(S) − 1) bus accesses.
- R5: When no wrap is seen at any offset below MAX_BYTES, which includes memories of MAX_BYTES or more, the run reports valid 0 and size MAX_BYTES.
- R6: Every bus write is addressed to the base address. No other location is ever written.
- R7: The last write of a run puts the saved word back at the base address, so that word is the same after done as it was before start.
- R8: A request keeps its address, direction and write data unchanged until the acknowledge arrives. The result and the access count do not depend on the acknowledge latency.
- R9: done is high for exactly one cycle per run. Size and valid change only in the done cycle and then hold their values. A start pulse during a run is ignored.
- R10: While reset is held and after it is released, request, done and valid are 0 and size is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe run (ignored while busy) |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address of the access |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid while bus_ack is high |
| bus_ack | input | 1 | Completes the current access |
| done | output | 1 | One-cycle pulse at the end of a run |
| size_valid | output | 1 | 1 = size determined (0 included), 0 = no wrap below maximum |
| size_bytes | output | AW | Detected size in bytes, MAX_BYTES when undetermined |

## Verification
The hardest cases to reach are the failures of the presence test. Those paths run only when the readback differs from what was written. The stimulus gets there with a bus model that has no memory behind it and returns the last value driven on the data lines. This shows that the dummy read is what makes an absent memory report size 0. A second bus model has a data bit stuck at 0. The first pattern passes on this model and the second fails, which exercises the second-pattern failure path. Memories of the maximum size and larger are used to reach the undetermined result.

// File: rtl/memsize_probe.sv
module memsize_probe #(
  parameter int unsigned      AW         = 32,
  parameter int unsigned      DW         = 32,
  parameter logic [AW-1:0]    MAX_BYTES  = 32'h0100_0000,
  parameter logic [AW-1:0]    BASE_ADDR  = '0,
  parameter logic [AW-1:0]    DUMMY_ADDR = 32'hFFF0_0000,
  parameter logic [DW-1:0]    PAT_A      = 32'h5555_AAAA,
  parameter logic [DW-1:0]    PAT_B      = 32'hAAAA_5555
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          done,
  output logic          size_valid,
  output logic [AW-1:0] size_bytes
);
  localparam logic [AW-1:0] FIRST_OFS = AW'(DW / 8);

  typedef enum logic [3:0] {
    S_IDLE, S_SAVE, S_WA, S_DA, S_RA, S_WB, S_DB, S_RB,
    S_STEP, S_RT, S_W0, S_R0, S_RT2, S_REST
  } st_t;

  st_t           st;
  logic [DW-1:0] saved, tmp;
  logic [AW-1:0] ofs, res_sz;
  logic          res_v;

  assign bus_req = (st != S_IDLE) && (st != S_STEP);
  assign bus_we  = (st == S_WA) || (st == S_WB) || (st == S_W0) || (st == S_REST);

  always_comb begin
    case (st)
      S_DA, S_DB:  bus_addr = DUMMY_ADDR;
      S_RT, S_RT2: bus_addr = BASE_ADDR + ofs;
      default:     bus_addr = BASE_ADDR;
    endcase
    case (st)
      S_WA:    bus_wdata = PAT_A;
      S_WB:    bus_wdata = PAT_B;
      S_W0:    bus_wdata = ~tmp;
      S_REST:  bus_wdata = saved;
      default: bus_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      saved      <= '0;
      tmp        <= '0;
      ofs        <= '0;
      res_sz     <= '0;
      res_v      <= 1'b0;
      done       <= 1'b0;
      size_valid <= 1'b0;
      size_bytes <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_SAVE;
        S_SAVE: if (bus_ack) begin saved <= bus_rdata; st <= S_WA; end
        S_WA:   if (bus_ack) st <= S_DA;
        S_DA:   if (bus_ack) st <= S_RA;
        S_RA: if (bus_ack) begin
          if (bus_rdata != PAT_A) begin
            res_sz <= '0; res_v <= 1'b1; st <= S_REST;
          end else st <= S_WB;
        end
        S_WB:   if (bus_ack) st <= S_DB;
        S_DB:   if (bus_ack) st <= S_RB;
        S_RB: if (bus_ack) begin
          if (bus_rdata != PAT_B) begin
            res_sz <= '0; res_v <= 1'b1; st <= S_REST;
          end else begin
            ofs <= FIRST_OFS; st <= S_STEP;
          end
        end
        S_STEP: begin
          if (ofs >= MAX_BYTES) begin
            res_sz <= MAX_BYTES; res_v <= 1'b0; st <= S_REST;
          end else st <= S_RT;
        end
        S_RT:   if (bus_ack) begin tmp <= bus_rdata; st <= S_W0; end
        S_W0:   if (bus_ack) st <= S_R0;
        S_R0:   if (bus_ack) begin tmp <= bus_rdata; st <= S_RT2; end
        S_RT2: if (bus_ack) begin
          if (bus_rdata == tmp) begin
            res_sz <= ofs; res_v <= 1'b1; st <= S_REST;
          end else begin
            ofs <= ofs << 1; st <= S_STEP;
          end
        end
        S_REST: if (bus_ack) begin
          done       <= 1'b1;
          size_bytes <= res_sz;
          size_valid <= res_v;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memsize_probe_chk.sv
module memsize_probe_chk #(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   DW        = 32,
  parameter logic [AW-1:0] MAX_BYTES = 32'h0100_0000,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          done,
  input logic          size_valid,
  input logic [AW-1:0] size_bytes
);
  logic busy;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy <= 1'b0;
    else if (done) busy <= start;
    else if (start) busy <= 1'b1;
  end

  p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> bus_req && !bus_we && bus_addr == BASE_ADDR);

  p_write_base_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_addr == BASE_ADDR);

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> done || ($stable(size_bytes) && $stable(size_valid)));

  p_size_pow2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && size_valid |-> $countones(size_bytes) <= 1 && size_bytes < MAX_BYTES);

  p_undet_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !size_valid |-> size_bytes == MAX_BYTES);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

bind memsize_probe memsize_probe_chk #(
  .AW(AW), .DW(DW), .MAX_BYTES(MAX_BYTES), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .done(done),
  .size_valid(size_valid), .size_bytes(size_bytes)
);

// File: tb/sim_memsize_probe.sv
module sim_memsize_probe;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAXB  = 32'h0010_0000;
  localparam logic [31:0] DUMMY = 32'hFFF0_0000;
  localparam logic [31:0] FLASH = 32'h1234_5678;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        bus_req, bus_we, bus_ack = 1'b0, done, size_valid;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0, size_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  memsize_probe #(.MAX_BYTES(MAXB), .DUMMY_ADDR(DUMMY)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done), .size_valid(size_valid), .size_bytes(size_bytes));

  // memory model
  logic [31:0] mem [int unsigned];
  bit          present = 1'b1, stuck = 1'b0;
  int unsigned words = 4;
  int          lat = 0, cnt = 0;
  logic [31:0] hold = '0;
  int          acc_cnt = 0, other_wr = 0;
  bit          first_we = 1'b0;
  logic [31:0] first_addr = '0;

  function automatic logic [31:0] model_rd(logic [31:0] a);
    int unsigned idx;
    logic [31:0] v;
    if (a == DUMMY) return FLASH;
    if (!present) return hold;
    idx = (a >> 2) & (words - 1);
    v = mem.exists(idx) ? mem[idx] : ((idx * 32'h9E37_79B9) ^ 32'h5A5A_0F0F);
    if (stuck) v[0] = 1'b0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst_n && bus_req && bus_ack) begin
      if (acc_cnt == 0) begin first_we = bus_we; first_addr = bus_addr; end
      acc_cnt = acc_cnt + 1;
      if (bus_we) begin
        if (bus_addr != 32'h0) other_wr = other_wr + 1;
        if (present && bus_addr != DUMMY)
          mem[(bus_addr >> 2) & (words - 1)] = stuck ? (bus_wdata & ~32'h1) : bus_wdata;
        hold = bus_wdata;
      end else if (bus_addr == DUMMY) hold = FLASH;
    end
    if (!rst_n) begin bus_ack <= 1'b0; cnt <= 0; end
    else if (bus_req && !bus_ack) begin
      if (cnt >= lat) begin bus_ack <= 1'b1; cnt <= 0; bus_rdata <= model_rd(bus_addr); end
      else cnt <= cnt + 1;
    end else begin bus_ack <= 1'b0; cnt <= 0; end
  end

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic prep(bit pres, int unsigned w, bit stk, int l, logic [31:0] seed);
    mem.delete();
    present = pres; words = w; stuck = stk; lat = l;
    mem[0] = seed;
    hold = '0; acc_cnt = 0; other_wr = 0;
  endtask

  task automatic run(output logic [31:0] sz, output logic v);
    bit got = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    chk("R9 done seen", 32'(got), 32'd1);
    sz = size_bytes; v = size_valid;
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
  endtask

  function automatic int log2i(logic [31:0] s);
    int n = 0;
    while ((32'd1 << n) < s) n++;
    return n;
  endfunction

  task automatic t_reset;
    chk("R10 req in reset", 32'(bus_req), 0);
    chk("R10 done in reset", 32'(done), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 req", 32'(bus_req), 0);
    chk("R10 valid", 32'(size_valid), 0);
    chk("R10 size", size_bytes, 0);
  endtask

  task automatic t_absent;
    logic [31:0] sz; logic v;
    prep(1'b0, 4, 1'b0, 0, 32'h0);
    run(sz, v);
    chk("R2 absent size", sz, 0);
    chk("R2 absent valid", 32'(v), 1);
    chk("R2 absent accesses", acc_cnt, 5);
    chk("R6 absent other writes", other_wr, 0);
  endtask

  task automatic t_stuck;
    logic [31:0] sz; logic v;
    prep(1'b1, 1024, 1'b1, 0, 32'hBEEF_0000);
    run(sz, v);
    chk("R3 stuck size", sz, 0);
    chk("R3 stuck valid", 32'(v), 1);
    chk("R3 stuck accesses", acc_cnt, 8);
  endtask

  task automatic t_size(logic [31:0] s, int l, logic [31:0] seed);
    logic [31:0] sz; logic v;
    prep(1'b1, s >> 2, 1'b0, l, seed);
    run(sz, v);
    chk("R4 size", sz, s);
    chk("R4 valid", 32'(v), 1);
    chk("R4/R8 access count", acc_cnt, 8 + 4 * (log2i(s) - 1));
    chk("R1 first access is read", 32'(first_we), 0);
    chk("R1 first access base", first_addr, 0);
    chk("R6 other writes", other_wr, 0);
    chk("R7 base restored", mem[0], seed);
  endtask

  task automatic t_undet(logic [31:0] s);
    logic [31:0] sz; logic v;
    prep(1'b1, s >> 2, 1'b0, 0, 32'h0BAD_F00D);
    run(sz, v);
    chk("R5 undet valid", 32'(v), 0);
    chk("R5 undet size", sz, MAXB);
    chk("R7 undet restored", mem[0], 32'h0BAD_F00D);
  endtask

  task automatic t_hold_ignore;
    logic [31:0] sz; logic v;
    int extra = 0;
    prep(1'b1, 64, 1'b0, 1, 32'h7777_1111);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    sz = size_bytes; v = size_valid;
    chk("R9 ignore size", sz, 256);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R9 no second run", extra, 0);
    chk("R9 held size", size_bytes, 256);
    chk("R9 held valid", 32'(size_valid), 1);
    chk("R7 ignore restored", mem[0], 32'h7777_1111);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_absent();
    t_stuck();
    t_size(32'd16, 0, 32'hC0DE_0001);
    t_size(32'd4096, 0, 32'hC0DE_0002);
    t_size(32'd4096, 3, 32'hC0DE_0003);
    t_size(32'd262144, 0, 32'hC0DE_0004);
    t_undet(MAXB);
    t_undet(MAXB << 1);
    t_hold_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule